// File: doc/BRIEF.md
# Sleep Mode Clock Controller

This block governs the low-power states of a small 8-bit processor core. It holds one power-control register in which software sets a halt bit (light sleep) or a deep-sleep bit, plus two spare flag bits that software may use freely. The register is read and written over a simple special-function-register bus. From the state of that register the block drives three clock controls: an enable for the CPU clock, an enable for the peripheral clocks and an enable for the oscillator. It also gives out a CPU clock that is already gated.

In light sleep only the CPU clock stops and the peripherals keep running. An enabled interrupt request, or reset, wakes the core. Deep sleep stops the oscillator and freezes every clock, and only reset ends it. If both sleep bits are written in the same write, deep sleep wins and the halt bit is dropped, so the core never falls into light sleep when it leaves deep sleep. The CPU enable is retimed on the falling clock edge, so the gated clock never produces a shortened pulse.

Top module: `sleep_clock_ctrl`

## Requirements
- R1: While rstIn is high, and after it is released, the register reads 0x00, modeStatus is 00 (run) and cpuClkEn, perClkEn and oscEn are all 1. Reset is asynchronous: the halt bit clears and modeStatus returns to 00 without a clock edge.
- R2: The register sits at address REG_ADDR. Bit 0 is the halt bit, bit 1 the deep-sleep bit, bit 2 flag F0 and bit 3 flag F1. Bits 7:4 read 0. A read at any other address returns 0, and a write to any other address changes nothing.
- R3: A write in run mode with bit 0 = 1 and bit 1 = 0 enters light sleep: modeStatus becomes 01, cpuClkEn goes to 0, perClkEn and oscEn stay 1, and cpuClkGated has no rising edge after the write cycle.
- R4: A write in run mode with bit 1 = 1 enters deep sleep: modeStatus becomes 10 and cpuClkEn, perClkEn and oscEn all go to 0.
- R5: A write with bits 1 and 0 both set enters deep sleep, and the register reads back with bit 0 = 0.
- R6: An irqPending sampled high in light sleep clears the halt bit at that clock edge. modeStatus returns to 00 and the CPU clock pulses again from the next edge. In run mode irqPending has no effect.
- R7: Deep sleep ends only with reset. irqPending and bus writes leave modeStatus at 10 and the register unchanged.
- R8: Bus writes are accepted only in run mode. A write issued in light sleep leaves the register unchanged.
- R9: F0 and F1 take the written value in run mode and keep it through light sleep and the wake-up by interrupt. Reset clears them.
- R10: modeStatus encodes 00 = run, 01 = light sleep, 10 = deep sleep, and never shows 11.
- R11: cpuClkEn changes only while clk is low, so every high phase of cpuClkGated lasts a full half period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running source clock |
| rstIn | input | 1 | Active-high asynchronous reset |
| sfrAddr | input | ADDR_W | Register bus address |
| sfrWrEn | input | 1 | Register bus write strobe |
| sfrWrData | input | DATA_W | Register bus write data |
| sfrRdData | output | DATA_W | Register bus read data (combinational) |
| irqPending | input | 1 | Enabled interrupt request from the interrupt controller |
| cpuClkEn | output | 1 | CPU clock enable, retimed on the falling edge |
| cpuClkGated | output | 1 | Gated CPU clock |
| perClkEn | output | 1 | Peripheral clock enable |
| oscEn | output | 1 | Oscillator enable |
| modeStatus | output | 2 | Current power mode code |

## Verification
On every clock edge the assertions check that the CPU enable agrees with the run code, that deep sleep has every enable low and keeps its register frozen, that light sleep keeps the peripherals and the oscillator running, that an interrupt in light sleep leads to run on the next edge, and that the two sleep bits are never both held. The bench's scenarios are the only place where the following show: the full sweep of write values with their decoded modes and read-back, the missing CPU clock pulses while asleep, the asynchronous wake on reset between edges, writes that are ignored in the sleep modes, and the pulse-width watch on the gated clock.

// File: rtl/sleep_clock_pkg.sv
package sleep_clock_pkg;

  typedef enum logic [1:0] {
    MODE_RUN  = 2'b00,
    MODE_IDLE = 2'b01,
    MODE_DEEP = 2'b10
  } pwrMode_e;

  localparam int HALT_BIT = 0;
  localparam int DEEP_BIT = 1;
  localparam int FLAG_LSB = 2;
  localparam int FLAG_W   = 2;
  localparam int USED_W   = FLAG_LSB + FLAG_W;

  typedef struct packed {
    logic wrAccept;
    logic clrHalt;
  } ctrlStrobe_t;

endpackage

// File: rtl/sleep_clock_regs.sv
module sleep_clock_regs
  import sleep_clock_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstIn,
  input  ctrlStrobe_t       strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic              haltQ,
  output logic              deepQ,
  output logic [FLAG_W-1:0] flagQ,
  output logic [DATA_W-1:0] regWord
);

  logic wantDeep;
  logic wantHalt;

  assign wantDeep = wrData[DEEP_BIT];
  assign wantHalt = wrData[HALT_BIT] & ~wantDeep;

  always_ff @(posedge clk or posedge rstIn) begin
    if (rstIn) begin
      haltQ <= 1'b0;
      deepQ <= 1'b0;
      flagQ <= '0;
    end else if (strobe.wrAccept) begin
      haltQ <= wantHalt;
      deepQ <= wantDeep;
      flagQ <= wrData[FLAG_LSB +: FLAG_W];
    end else if (strobe.clrHalt) begin
      haltQ <= 1'b0;
    end
  end

  always_comb begin
    regWord = '0;
    regWord[HALT_BIT] = haltQ;
    regWord[DEEP_BIT] = deepQ;
    regWord[FLAG_LSB +: FLAG_W] = flagQ;
  end

endmodule

// File: rtl/sleep_clock_fsm.sv
module sleep_clock_fsm
  import sleep_clock_pkg::*;
#(
  parameter int               ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h47
) (
  input  logic              sfrWrEn,
  input  logic [ADDR_W-1:0] sfrAddr,
  input  logic              irqPending,
  input  logic              haltQ,
  input  logic              deepQ,
  output ctrlStrobe_t       strobe,
  output pwrMode_e          mode,
  output logic              addrHit,
  output logic              cpuEnReq,
  output logic              perClkEn,
  output logic              oscEn
);

  always_comb begin
    if (deepQ)      mode = MODE_DEEP;
    else if (haltQ) mode = MODE_IDLE;
    else            mode = MODE_RUN;
  end

  assign addrHit = (sfrAddr == REG_ADDR);

  always_comb begin
    strobe.wrAccept = sfrWrEn & addrHit & (mode == MODE_RUN);
    strobe.clrHalt  = irqPending & (mode == MODE_IDLE);
  end

  assign cpuEnReq = (mode == MODE_RUN);
  assign perClkEn = (mode != MODE_DEEP);
  assign oscEn    = (mode != MODE_DEEP);

endmodule

// File: rtl/sleep_clock_gate.sv
module sleep_clock_gate (
  input  logic clk,
  input  logic rstIn,
  input  logic enReq,
  output logic enQ,
  output logic gatedClk
);

  // Enable is retimed on the falling edge, so it only moves while clk is low.
  always_ff @(negedge clk or posedge rstIn) begin
    if (rstIn) enQ <= 1'b1;
    else       enQ <= enReq;
  end

  assign gatedClk = clk & enQ;

endmodule

// File: rtl/sleep_clock_ctrl.sv
module sleep_clock_ctrl
  import sleep_clock_pkg::*;
#(
  parameter int               ADDR_W   = 8,
  parameter int               DATA_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h47
) (
  input  logic              clk,
  input  logic              rstIn,
  input  logic [ADDR_W-1:0] sfrAddr,
  input  logic              sfrWrEn,
  input  logic [DATA_W-1:0] sfrWrData,
  output logic [DATA_W-1:0] sfrRdData,
  input  logic              irqPending,
  output logic              cpuClkEn,
  output logic              cpuClkGated,
  output logic              perClkEn,
  output logic              oscEn,
  output logic [1:0]        modeStatus
);

  ctrlStrobe_t       strobe;
  pwrMode_e          mode;
  logic              haltQ;
  logic              deepQ;
  logic [FLAG_W-1:0] flagQ;
  logic [DATA_W-1:0] regWord;
  logic              addrHit;
  logic              cpuEnReq;

  sleep_clock_fsm #(
    .ADDR_W  (ADDR_W),
    .REG_ADDR(REG_ADDR)
  ) u_fsm (
    .sfrWrEn   (sfrWrEn),
    .sfrAddr   (sfrAddr),
    .irqPending(irqPending),
    .haltQ     (haltQ),
    .deepQ     (deepQ),
    .strobe    (strobe),
    .mode      (mode),
    .addrHit   (addrHit),
    .cpuEnReq  (cpuEnReq),
    .perClkEn  (perClkEn),
    .oscEn     (oscEn)
  );

  sleep_clock_regs #(
    .DATA_W(DATA_W)
  ) u_regs (
    .clk    (clk),
    .rstIn  (rstIn),
    .strobe (strobe),
    .wrData (sfrWrData),
    .haltQ  (haltQ),
    .deepQ  (deepQ),
    .flagQ  (flagQ),
    .regWord(regWord)
  );

  sleep_clock_gate u_gate (
    .clk     (clk),
    .rstIn   (rstIn),
    .enReq   (cpuEnReq),
    .enQ     (cpuClkEn),
    .gatedClk(cpuClkGated)
  );

  assign sfrRdData  = addrHit ? regWord : '0;
  assign modeStatus = mode;

endmodule

// File: rtl/sleep_clock_ctrl_chk.sv
module sleep_clock_ctrl_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstIn,
  input logic              irqPending,
  input logic              cpuClkEn,
  input logic              perClkEn,
  input logic              oscEn,
  input logic [1:0]        modeStatus,
  input logic [DATA_W-1:0] regWord
);

  p_cpu_en_tracks_run_r3: assert property (@(posedge clk) disable iff (rstIn)
    cpuClkEn == (modeStatus == 2'b00));

  p_deep_all_off_r4: assert property (@(posedge clk) disable iff (rstIn)
    (modeStatus == 2'b10) |-> (!cpuClkEn && !perClkEn && !oscEn));

  p_idle_periph_on_r3: assert property (@(posedge clk) disable iff (rstIn)
    (modeStatus == 2'b01) |-> (perClkEn && oscEn));

  p_irq_wakes_r6: assert property (@(posedge clk) disable iff (rstIn)
    (modeStatus == 2'b01 && irqPending) |=> (modeStatus == 2'b00));

  p_deep_frozen_r7: assert property (@(posedge clk) disable iff (rstIn)
    (modeStatus == 2'b10) |=> (modeStatus == 2'b10 && $stable(regWord)));

  p_flags_kept_r9: assert property (@(posedge clk) disable iff (rstIn)
    (modeStatus != 2'b00) |=> $stable(regWord[3:2]));

  p_mode_legal_r10: assert property (@(posedge clk) disable iff (rstIn)
    modeStatus != 2'b11);

  p_upper_zero_r2: assert property (@(posedge clk) disable iff (rstIn)
    regWord[DATA_W-1:4] == '0);

  p_no_double_sleep_r5: assert property (@(posedge clk) disable iff (rstIn)
    !(regWord[0] && regWord[1]));

endmodule

bind sleep_clock_ctrl sleep_clock_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rstIn     (rstIn),
  .irqPending(irqPending),
  .cpuClkEn  (cpuClkEn),
  .perClkEn  (perClkEn),
  .oscEn     (oscEn),
  .modeStatus(modeStatus),
  .regWord   (regWord)
);

// File: tb/sleep_clock_ctrl_test.sv
`timescale 1ns/1ps
module sleep_clock_ctrl_test;

  localparam logic [7:0] REG_A   = 8'h47;
  localparam logic [7:0] OTHER_A = 8'h12;

  logic       clk = 1'b0;
  logic       rstIn = 1'b1;
  logic [7:0] sfrAddr = REG_A;
  logic       sfrWrEn = 1'b0;
  logic [7:0] sfrWrData = 8'h00;
  logic [7:0] sfrRdData;
  logic       irqPending = 1'b0;
  logic       cpuClkEn, cpuClkGated, perClkEn, oscEn;
  logic [1:0] modeStatus;

  int checks = 0;
  int failures = 0;
  int gatedEdges = 0;
  int runtCount = 0;
  int enMoveHigh = 0;
  bit finished = 0;
  realtime riseAt = 0.0;

  always #4 clk = ~clk;

  sleep_clock_ctrl uut (
    .clk(clk), .rstIn(rstIn), .sfrAddr(sfrAddr), .sfrWrEn(sfrWrEn),
    .sfrWrData(sfrWrData), .sfrRdData(sfrRdData), .irqPending(irqPending),
    .cpuClkEn(cpuClkEn), .cpuClkGated(cpuClkGated), .perClkEn(perClkEn),
    .oscEn(oscEn), .modeStatus(modeStatus)
  );

  always @(posedge cpuClkGated) begin
    gatedEdges++;
    riseAt = $realtime;
  end
  always @(negedge cpuClkGated) if ($realtime - riseAt < 3.9) runtCount++;
  always @(cpuClkEn) if (clk && !rstIn) enMoveHigh++;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk); #1 rstIn = 1'b1;
    @(negedge clk); #1 rstIn = 1'b0;
    sfrAddr = REG_A;
  endtask

  task automatic busWrite(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    sfrAddr = a; sfrWrData = d; sfrWrEn = 1'b1;
    @(negedge clk);
    sfrWrEn = 1'b0; sfrAddr = REG_A;
    #1;
  endtask

  task automatic pulseIrq();
    @(negedge clk); irqPending = 1'b1;
    @(negedge clk); irqPending = 1'b0;
    #1;
  endtask

  task automatic idleClocks(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int snap;
    logic [7:0] expRd;
    logic [1:0] expMode;

    // R1 during and after reset
    #2;
    check("R1 rd in reset", sfrRdData, 8'h00);
    check("R1 mode in reset", modeStatus, 2'b00);
    idleClocks(2);
    rstIn = 1'b0;
    idleClocks(1);
    check("R1 rd after reset", sfrRdData, 8'h00);
    check("R1 mode", modeStatus, 2'b00);
    check("R1 enables", {cpuClkEn, perClkEn, oscEn}, 3'b111);

    // R2 R3 R4 R5 R10: sweep every write value from run mode
    for (int v = 0; v < 256; v++) begin
      doReset();
      busWrite(REG_A, v[7:0]);
      expRd = {4'b0, v[3], v[2], v[1], v[0] & ~v[1]};
      expMode = v[1] ? 2'b10 : (v[0] ? 2'b01 : 2'b00);
      check("R2 R5 readback", sfrRdData, expRd);
      check("R10 mode code", modeStatus, expMode);
      check("R3 R4 enables", {cpuClkEn, perClkEn, oscEn},
            v[1] ? 3'b000 : (v[0] ? 3'b011 : 3'b111));
    end

    // R2 other address ignored and reads zero
    doReset();
    busWrite(OTHER_A, 8'h0F);
    check("R2 other write ignored", sfrRdData, 8'h00);
    check("R2 other write mode", modeStatus, 2'b00);
    sfrAddr = OTHER_A; #1;
    check("R2 other read zero", sfrRdData, 8'h00);
    busWrite(REG_A, 8'h0C);
    sfrAddr = OTHER_A; #1;
    check("R2 other read zero with flags", sfrRdData, 8'h00);
    sfrAddr = REG_A; #1;

    // R6 irq in run has no effect
    pulseIrq();
    check("R6 irq in run", sfrRdData, 8'h0C);

    // R3 idle: no CPU edges; R9 flags kept; R8 write ignored
    busWrite(REG_A, 8'h0D);
    snap = gatedEdges;
    idleClocks(6);
    check("R3 no cpu edges in idle", gatedEdges, snap);
    check("R3 idle mode", modeStatus, 2'b01);
    busWrite(REG_A, 8'h02);
    check("R8 write in idle ignored", sfrRdData, 8'h0D);
    check("R8 mode stays idle", modeStatus, 2'b01);

    // R6 wake by irq
    pulseIrq();
    check("R6 wake mode", modeStatus, 2'b00);
    check("R6 cpu enable back", cpuClkEn, 1'b1);
    check("R9 flags after wake", sfrRdData, 8'h0C);
    snap = gatedEdges;
    idleClocks(3);
    check("R6 cpu clock resumes", gatedEdges - snap, 3);

    // R7 deep sleep ignores irq and writes
    busWrite(REG_A, 8'h0A);
    snap = gatedEdges;
    pulseIrq();
    busWrite(REG_A, 8'h00);
    idleClocks(3);
    check("R7 deep mode held", modeStatus, 2'b10);
    check("R7 deep reg held", sfrRdData, 8'h0A);
    check("R7 no cpu edges", gatedEdges, snap);
    check("R4 deep enables", {cpuClkEn, perClkEn, oscEn}, 3'b000);

    // R5 both bits: leaves deep via reset straight to run
    doReset();
    busWrite(REG_A, 8'h03);
    check("R5 both set mode", modeStatus, 2'b10);
    doReset();
    idleClocks(2);
    check("R5 after reset run", modeStatus, 2'b00);
    check("R9 reset clears flags", sfrRdData, 8'h00);

    // R1 asynchronous reset wakes idle between edges
    busWrite(REG_A, 8'h05);
    check("R1 idle before async", modeStatus, 2'b01);
    @(negedge clk); #1 rstIn = 1'b1;
    #1;
    check("R1 async mode", modeStatus, 2'b00);
    check("R1 async rd", sfrRdData, 8'h00);
    check("R1 async cpu en", cpuClkEn, 1'b1);
    @(negedge clk); #1 rstIn = 1'b0;
    idleClocks(2);

    // R11 glitch-free gating
    check("R11 runt pulses", runtCount, 0);
    check("R11 enable moved while clk high", enMoveHigh, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule